// File: doc/BRIEF.md
# Resumable Memory-to-Memory Block Copy Sequencer

This block moves a run of equally sized elements from one memory region to another. It keeps three working registers: a source pointer, a destination pointer and a remaining-element count. Software or a surrounding controller loads these registers while the engine is idle. A start command then selects the element size: byte, half-word (2 bytes) or word (4 bytes). For every element the engine reads through the source pointer, keeps the value in an internal holding register, and writes it through the destination pointer. It then steps both pointers by the element size and decrements the count.

Memory is reached through a single-port request channel with a valid/ready handshake. Reads return data in the same cycle that ready is high. An interrupt request input can break the move off, but only between elements. When that happens the engine stops with a suspended flag raised, and its registers describe exactly the work that is left. Issuing the start command again finishes the move with nothing repeated and nothing skipped.

Top module: `blkcopy_engine`

## Requirements
- R1: Each element is exactly one read at the source pointer (request write-enable low) followed directly by one write at the destination pointer (write-enable high). After a read handshake the next request is that element's write.
- R2: After each element's write handshake, both pointers grow by the element size. Size code 0 gives 1, code 1 gives 2, code 2 gives 4, and code 3 also gives 4. The size code on the request port equals the code given at start.
- R3: The count falls by one per element. When the last element is written, busy drops, done rises and count reads 0. Done and suspended are never high together.
- R4: The source pointer, destination pointer and count outputs always show the remaining work: the start values advanced by the number of elements already completed.
- R5: An interrupt request sampled high at an element's write handshake, when that element is not the last, ends the move after that element. Suspended is set and done stays low. At least one element is always copied after a start, and an element whose read has been issued always completes its write.
- R6: Starting again after a suspension continues from the register contents. The destination ends up as an exact copy of the source, and the total number of reads equals the original count.
- R7: A start with count 0 raises done one cycle later, issues no memory request and leaves busy low.
- R8: While a request is valid and not yet ready, the address, write-enable and write data stay unchanged.
- R9: The data written for an element equals the data returned by that element's read.
- R10: A register load request or a start command is ignored while the engine is busy.
- R11: After reset, all registers read 0, and busy, done, suspended and request valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req | input | 1 | Load the three working registers (idle only) |
| ld_src | input | AW | Source pointer value to load |
| ld_dst | input | AW | Destination pointer value to load |
| ld_cnt | input | CW | Element count value to load |
| cmd_start | input | 1 | Start or resume the move (idle only) |
| cmd_size | input | 2 | Element size code: 0 byte, 1 half-word, 2 or 3 word |
| irq_req | input | 1 | Interrupt request, honoured at element boundaries |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | DW | Write data, low bytes used for small sizes |
| mem_size | output | 2 | Element size code of the request |
| mem_rdata | input | DW | Read data, valid with the read handshake |
| busy | output | 1 | A move is in progress |
| done | output | 1 | Last move finished (sticky until next start) |
| suspended | output | 1 | Last move stopped by interrupt (sticky until next start) |
| src_ptr | output | AW | Current source pointer |
| dst_ptr | output | AW | Current destination pointer |
| count | output | CW | Elements still to copy |

## Verification
The bench interrupts moves after the first element, in the middle and one element before the end. It then resumes each one and compares every destination byte, plus the byte just past the region, against the pattern held at the source. A design that stepped its pointers before the write finished, or suspended inside an element, would either copy an element twice or leave a hole. The bench also checks zero-count starts: an engine that launched a read anyway, or never raised done, is caught. Memory stalls are inserted on a fixed rhythm, so an engine that changed its request while waiting for ready would corrupt the copy. Loads driven during a move must leave the final pointers untouched. Size code 3 must step by four.

// File: rtl/blkcopy_pkg.sv
`timescale 1ns/1ps
package blkcopy_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } elem_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  // Byte stride of one element for a size code (code 3 strides like code 2).
  function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: elem_bytes = 3'd1;
      SZ_HALF: elem_bytes = 3'd2;
      default: elem_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/blkcopy_ptrs.sv
`timescale 1ns/1ps
module blkcopy_ptrs #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_src,
  input  logic [AW-1:0] load_dst,
  input  logic [CW-1:0] load_cnt,
  input  logic          advance,
  input  logic [2:0]    stride,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q
);

  localparam int NPTR = 2;

  logic [AW-1:0] ptr_q   [NPTR];
  logic [AW-1:0] ptr_ld  [NPTR];

  assign ptr_ld[0] = load_src;
  assign ptr_ld[1] = load_dst;

  // Both pointers share one update rule, so one register is built per pointer.
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr_q[g] <= '0;
      else if (load_en)
        ptr_q[g] <= ptr_ld[g];
      else if (advance)
        ptr_q[g] <= ptr_q[g] + AW'(stride);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load_en)
      cnt_q <= load_cnt;
    else if (advance)
      cnt_q <= cnt_q - CW'(1);
  end

  assign src_q = ptr_q[0];
  assign dst_q = ptr_q[1];

endmodule

// File: rtl/blkcopy_seq.sv
`timescale 1ns/1ps
module blkcopy_seq
  import blkcopy_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    size_in,
  input  logic          irq,
  input  logic [AW-1:0] src_q,
  input  logic [AW-1:0] dst_q,
  input  logic [CW-1:0] cnt_q,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [1:0]    mem_size,
  output logic          busy,
  output logic          done,
  output logic          suspended,
  output logic          start_acc,
  output logic          rd_done,
  output logic          elem_done,
  output logic [2:0]    stride
);

  seq_state_e    state_q;
  logic [1:0]    size_q;
  logic [DW-1:0] hold_q;
  logic          last_elem;
  logic          zero_start;

  assign busy       = (state_q != ST_IDLE);
  assign start_acc  = start && !busy;
  assign zero_start = start_acc && (cnt_q == '0);
  assign rd_done    = (state_q == ST_READ)  && mem_ready;
  assign elem_done  = (state_q == ST_WRITE) && mem_ready;
  assign last_elem  = (cnt_q == CW'(1));
  assign stride     = elem_bytes(size_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      size_q    <= '0;
      hold_q    <= '0;
      done      <= 1'b0;
      suspended <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_acc) begin
          size_q    <= size_in;
          suspended <= 1'b0;
          done      <= zero_start;
          state_q   <= zero_start ? ST_IDLE : ST_READ;
        end
        ST_READ: if (rd_done) begin
          hold_q  <= mem_rdata;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (elem_done) begin
          if (last_elem) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (irq) begin
            suspended <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            state_q <= ST_READ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid = busy;
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = mem_we ? dst_q : src_q;
  assign mem_wdata = hold_q;
  assign mem_size  = size_q;

endmodule

// File: rtl/blkcopy_engine.sv
`timescale 1ns/1ps
module blkcopy_engine #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_req,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  logic          cmd_start,
  input  logic [1:0]    cmd_size,
  input  logic          irq_req,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [1:0]    mem_size,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          suspended,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] count
);

  logic       start_acc;
  logic       rd_done;
  logic       elem_done;
  logic [2:0] step_w;
  logic       load_ok;

  assign load_ok = ld_req && !busy;

  blkcopy_ptrs #(.AW(AW), .CW(CW)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_ok),
    .load_src (ld_src),
    .load_dst (ld_dst),
    .load_cnt (ld_cnt),
    .advance  (elem_done),
    .stride   (step_w),
    .src_q    (src_ptr),
    .dst_q    (dst_ptr),
    .cnt_q    (count)
  );

  blkcopy_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cmd_start),
    .size_in   (cmd_size),
    .irq       (irq_req),
    .src_q     (src_ptr),
    .dst_q     (dst_ptr),
    .cnt_q     (count),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_size  (mem_size),
    .busy      (busy),
    .done      (done),
    .suspended (suspended),
    .start_acc (start_acc),
    .rd_done   (rd_done),
    .elem_done (elem_done),
    .stride    (step_w)
  );

endmodule

// File: rtl/blkcopy_chk.sv
`timescale 1ns/1ps
module blkcopy_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          busy,
  input logic          done,
  input logic          suspended,
  input logic          start_acc,
  input logic          elem_done,
  input logic [2:0]    step,
  input logic [AW-1:0] src_ptr,
  input logic [AW-1:0] dst_ptr,
  input logic [CW-1:0] count
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R8

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !mem_we |=> mem_valid && mem_we); // R1

  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> src_ptr == $past(src_ptr) + AW'($past(step))); // R2

  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> dst_ptr == $past(dst_ptr) + AW'($past(step))); // R2

  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> count == $past(count) - CW'(1)); // R3

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> count == '0 && !busy); // R3

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && suspended)); // R3

  AST_SUSP_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(elem_done) && !busy); // R5

  AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc && count == '0 |=> done && !busy && !mem_valid); // R7

endmodule

bind blkcopy_engine blkcopy_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .busy      (busy),
  .done      (done),
  .suspended (suspended),
  .start_acc (start_acc),
  .elem_done (elem_done),
  .step      (step_w),
  .src_ptr   (src_ptr),
  .dst_ptr   (dst_ptr),
  .count     (count)
);

// File: tb/sim_blkcopy_engine.sv
`timescale 1ns/1ps
module sim_blkcopy_engine;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 16;

  typedef struct packed {
    logic [7:0] src;
    logic [7:0] dst;
    logic [7:0] cnt;
    logic [1:0] sz;
    logic [7:0] irq_at;   // 0 = no interrupt, k = interrupt at element k
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{8'h10, 8'h80, 8'd5, 2'd0, 8'd0},
    '{8'h20, 8'h90, 8'd3, 2'd1, 8'd0},
    '{8'h30, 8'hA0, 8'd4, 2'd2, 8'd0},
    '{8'h11, 8'hC1, 8'd6, 2'd0, 8'd2},
    '{8'h40, 8'hD0, 8'd5, 2'd2, 8'd4},
    '{8'h22, 8'hB0, 8'd3, 2'd3, 8'd0},
    '{8'h50, 8'hE8, 8'd4, 2'd1, 8'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_req = 1'b0;
  logic [AW-1:0] ld_src = '0;
  logic [AW-1:0] ld_dst = '0;
  logic [CW-1:0] ld_cnt = '0;
  logic          cmd_start = 1'b0;
  logic [1:0]    cmd_size = '0;
  logic          irq_req;
  logic          mem_valid, mem_ready, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [1:0]    mem_size;
  logic          busy, done, suspended;
  logic [AW-1:0] src_ptr, dst_ptr;
  logic [CW-1:0] count;

  always #5 clk = ~clk;

  blkcopy_engine #(.AW(AW), .DW(DW), .CW(CW)) u0 (.*);

  // ---------------- memory model ----------------
  logic [7:0] mem [256];
  logic       init_go = 1'b0;
  logic [7:0] seed = '0;
  logic [2:0] rcyc = '0;
  int         rd_cnt = 0;
  int         wr_cnt = 0;
  logic       irq_arm = 1'b0;
  int         irq_at = 0;

  function automatic logic [7:0] pat(input int a, input logic [7:0] s);
    pat = 8'((a * 37) ^ s ^ 8'h5A);
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    nbytes = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  assign mem_ready = (rcyc != 3'd2) && (rcyc != 3'd5);
  assign irq_req   = irq_arm && (wr_cnt + 1 >= irq_at);

  always_comb begin
    mem_rdata = '0;
    for (int k = 0; k < nbytes(mem_size); k++)
      mem_rdata[8*k +: 8] = mem[8'(mem_addr[7:0] + 8'(k))];
  end

  always @(posedge clk) begin
    rcyc <= rcyc + 3'd1;
    if (init_go) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i, seed);
      rd_cnt <= 0;
      wr_cnt <= 0;
    end else if (mem_valid && mem_ready) begin
      if (mem_we) begin
        for (int k = 0; k < nbytes(mem_size); k++)
          mem[8'(mem_addr[7:0] + 8'(k))] <= mem_wdata[8*k +: 8];
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  // ---------------- checking ----------------
  int  n_run = 0;
  int  n_fail = 0;
  bit  reported = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic init_mem(input logic [7:0] s);
    @(negedge clk);
    seed = s; init_go = 1'b1;
    @(negedge clk);
    init_go = 1'b0;
  endtask

  task automatic load(input int s, input int d, input int c);
    @(negedge clk);
    ld_req = 1'b1; ld_src = AW'(s); ld_dst = AW'(d); ld_cnt = CW'(c);
    @(negedge clk);
    ld_req = 1'b0;
  endtask

  task automatic start(input logic [1:0] sz);
    @(negedge clk);
    cmd_start = 1'b1; cmd_size = sz;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic wait_stop(input string req);
    int t;
    t = 0;
    while (busy && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(!busy, req, longint'(busy), 0);
  endtask

  // dst region equals src pattern, and the byte just past it is untouched
  task automatic chk_copy(input int s, input int d, input int bytes, input string req);
    int bad;
    bad = 0;
    for (int j = 0; j < bytes; j++)
      if (mem[8'(d + j)] != pat(8'(s + j), seed)) bad++;
    chk(bad == 0, req, bad, 0);
    chk(mem[8'(d + bytes)] == pat(8'(d + bytes), seed), req,
        mem[8'(d + bytes)], pat(8'(d + bytes), seed));
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !suspended && !mem_valid, "R11 flags", {busy, done, suspended, mem_valid}, 0);
    chk(src_ptr == 0 && dst_ptr == 0 && count == 0, "R11 regs", {src_ptr, dst_ptr, count}, 0);

    // ---------------- table walk ----------------
    for (int v = 0; v < NV; v++) begin
      automatic vec_t x = VEC[v];
      automatic int st = nbytes(x.sz);
      init_mem(8'(v * 19 + 3));
      load(x.src, x.dst, x.cnt);
      chk(src_ptr == AW'(x.src) && dst_ptr == AW'(x.dst) && count == CW'(x.cnt), "R4 load",
          {src_ptr, dst_ptr, count}, {16'(x.src), 16'(x.dst), 16'(x.cnt)});
      irq_at = x.irq_at;
      irq_arm = (x.irq_at != 0);
      start(x.sz);
      wait_stop("R3 stop");
      if (x.irq_at != 0) begin
        automatic int k = x.irq_at;
        chk(suspended && !done, "R5 suspended", {suspended, done}, 2'b10);
        chk(count == CW'(x.cnt - k), "R4 count at suspend", count, x.cnt - k);
        chk(src_ptr == AW'(x.src + k * st), "R4 src at suspend", src_ptr, x.src + k * st);
        chk(dst_ptr == AW'(x.dst + k * st), "R4 dst at suspend", dst_ptr, x.dst + k * st);
        chk(wr_cnt == k, "R5 elements before suspend", wr_cnt, k);
        irq_arm = 1'b0;
        start(x.sz);
        wait_stop("R6 resume stop");
        chk(rd_cnt == x.cnt && wr_cnt == x.cnt, "R6 no repeat", rd_cnt, x.cnt);
      end else begin
        chk(rd_cnt == x.cnt && wr_cnt == x.cnt, "R1 access count", rd_cnt, x.cnt);
      end
      chk(done && !suspended && count == 0, "R3 done", {done, suspended, count}, {2'b10, 16'd0});
      chk(src_ptr == AW'(x.src + x.cnt * st), "R2 src final", src_ptr, x.src + x.cnt * st);
      chk(dst_ptr == AW'(x.dst + x.cnt * st), "R2 dst final", dst_ptr, x.dst + x.cnt * st);
      chk_copy(x.src, x.dst, x.cnt * st, "R9 R6 copy");
    end

    // ---------------- directed: zero count ----------------
    init_mem(8'h33);
    load(8'h10, 8'h80, 0);
    start(2'd2);
    chk(done && !busy && !mem_valid, "R7 zero count done", {done, busy, mem_valid}, 3'b100);
    repeat (3) @(negedge clk);
    chk(rd_cnt == 0 && wr_cnt == 0, "R7 no access", rd_cnt + wr_cnt, 0);

    // ---------------- directed: load and start while busy ----------------
    init_mem(8'h44);
    load(8'h60, 8'hF0, 4);
    start(2'd0);
    @(negedge clk);
    ld_req = 1'b1; ld_src = 16'h0000; ld_dst = 16'h0001; ld_cnt = 16'd9;
    cmd_start = 1'b1; cmd_size = 2'd2;
    @(negedge clk);
    ld_req = 1'b0; cmd_start = 1'b0;
    wait_stop("R10 stop");
    chk(src_ptr == 16'h64 && dst_ptr == 16'hF4 && count == 0, "R10 load ignored",
        {src_ptr, dst_ptr, count}, {16'h64, 16'hF4, 16'd0});
    chk(mem_size == 2'd0 && wr_cnt == 4, "R10 start ignored", {mem_size, wr_cnt}, 4);
    chk_copy(8'h60, 8'hF0, 4, "R10 copy");

    report();
  end

endmodule